// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the memory traffic of a 16-bit core when it enters or leaves an interrupt handler. It is started by one of four sources: a software interrupt strobe carrying an 8-bit type, a maskable hardware request carrying its own type, a non-maskable request, or an interrupt-return strobe. On entry it saves the flag word, the code segment and the instruction pointer on a stack that grows toward lower addresses. It then reads the handler's new instruction pointer and code segment from a vector table at the bottom of memory. On return it reads the three saved words back.

The sequencer uses a byte-wide memory port and makes one access per clock. Read data must be valid in the same cycle as the address. When the accesses are finished, the block presents the new flags, CS, IP and SP for one cycle. The surrounding core copies them into its architectural registers. A halt input puts the sequencer in a halted state that only a hardware request can end.

Top module: `irq_seq_top`

## Requirements
- R1: On entry the vector is read from physical address type×4 upward, one byte per cycle: IP low, IP high, CS low, CS high. The non-maskable source uses type 2.
- R2: Entry first writes six bytes, one per cycle, at SS×16 + offset (modulo 2^20). The saved words go in the order flags, CS, IP. Before each word the 16-bit offset is lowered by 2, with wrap-around, and the low byte is written at the lower address.
- R3: When entry completes, the new flags equal the saved flags with bit 9 (interrupt enable) and bit 8 (trap) cleared, and the new SP equals the old SP minus 6.
- R4: Return reads six bytes at SS×16 + SP + 0..5, in the order IP, CS, flags, each word low byte first. It then reports those words together with SP plus 6.
- R5: A maskable request is taken only while flags bit 9 is 1. Otherwise it leaves the block idle.
- R6: A non-maskable request is taken whatever flags bit 9 holds. It wins over a maskable request present in the same cycle.
- R7: Requests are sampled only while idle. In one cycle the priority is non-maskable, then maskable, then software, then return. A request that arrives during a sequence in progress is taken only after that sequence has finished.
- R8: A halt strobe seen while idle, with no request taken, sets the halted output. While halted, software and return strobes are ignored. A taken hardware request clears the halted state.
- R9: Busy rises in the cycle after a request is taken. It stays high for 10 access cycles on entry or 6 on return, plus one done cycle. Busy falls in the cycle after done.
- R10: After reset, busy, done and halted are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 1 | Software interrupt strobe |
| sw_type | input | 8 | Software interrupt type |
| hw_req | input | 1 | Maskable request level |
| hw_type | input | 8 | Maskable request type |
| nmi_req | input | 1 | Non-maskable request level |
| iret_req | input | 1 | Interrupt-return strobe |
| halt_req | input | 1 | Halt strobe |
| flags_in | input | 16 | Current flag word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| mem_addr | output | 20 | Byte address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| new_flags | output | 16 | Resulting flag word, valid while done |
| new_cs | output | 16 | Resulting code segment, valid while done |
| new_ip | output | 16 | Resulting instruction pointer, valid while done |
| new_sp | output | 16 | Resulting stack pointer, valid while done |
| done | output | 1 | One-cycle completion indicator |
| busy | output | 1 | Sequence in progress |
| halted | output | 1 | Halted state |

## Verification
Two kinds of coincidence are driven on purpose. In the first, a non-maskable and a maskable request rise in the same idle cycle, and the bench checks that the vector reads land at type 2. In the second, a maskable request rises while a software entry is still writing the stack. For this case the expected access stream is the software entry running to its end, followed after the done cycle by a second entry for the hardware type. A software strobe and a return strobe are also raised together, and a halt is attempted while requests are masked. On every clock the reference model's expected address, strobe and data are compared with the port.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  localparam int SAVED_WORDS = 3;
  localparam int VEC_BYTES   = 4;
  localparam int PUSH_STEPS  = 2 * SAVED_WORDS;
  localparam int ENTRY_STEPS = PUSH_STEPS + VEC_BYTES;
  localparam int RET_STEPS   = 2 * SAVED_WORDS;
  localparam int NMI_TYPE    = 2;
  localparam int IE_BIT      = 9;
  localparam int TRAP_BIT    = 8;
endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb
  import irq_seq_pkg::*;
#(
  parameter int TYPE_W = 8
) (
  input  logic              idle,
  input  logic              halted,
  input  logic              nmi_req,
  input  logic              hw_req,
  input  logic              ie_set,
  input  logic              sw_req,
  input  logic              iret_req,
  input  logic              halt_req,
  input  logic [TYPE_W-1:0] hw_type,
  input  logic [TYPE_W-1:0] sw_type,
  output logic              take,
  output logic              take_entry,
  output logic              wake,
  output logic              go_halt,
  output logic [TYPE_W-1:0] take_type
);
  always_comb begin
    take       = 1'b0;
    take_entry = 1'b0;
    wake       = 1'b0;
    go_halt    = 1'b0;
    take_type  = '0;
    if (idle) begin
      if (nmi_req) begin
        take       = 1'b1;
        take_entry = 1'b1;
        wake       = 1'b1;
        take_type  = TYPE_W'(NMI_TYPE);
      end else if (hw_req && ie_set) begin
        take       = 1'b1;
        take_entry = 1'b1;
        wake       = 1'b1;
        take_type  = hw_type;
      end else if (!halted && sw_req) begin
        take       = 1'b1;
        take_entry = 1'b1;
        take_type  = sw_type;
      end else if (!halted && iret_req) begin
        take       = 1'b1;
      end else if (halt_req) begin
        go_halt    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              take_entry,
  input  logic              wake,
  input  logic              go_halt,
  output logic              idle,
  output logic              run,
  output logic              done,
  output logic              halted,
  output logic              entry,
  output logic [STEP_W-1:0] step
);
  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d, last_step;
  logic              entry_q, entry_d, halted_q, halted_d;

  assign last_step = entry_q ? STEP_W'(ENTRY_STEPS - 1) : STEP_W'(RET_STEPS - 1);

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    entry_d  = entry_q;
    halted_d = halted_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (take) begin
          state_d = SEQ_RUN;
          step_d  = '0;
          entry_d = take_entry;
        end
        if (wake)    halted_d = 1'b0;
        if (go_halt) halted_d = 1'b1;
      end
      SEQ_RUN: begin
        if (step_q == last_step) state_d = SEQ_DONE;
        else                     step_d  = step_q + 1'b1;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      step_q   <= '0;
      entry_q  <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      step_q   <= step_d;
      entry_q  <= entry_d;
      halted_q <= halted_d;
    end
  end

  assign idle   = (state_q == SEQ_IDLE);
  assign run    = (state_q == SEQ_RUN);
  assign done   = (state_q == SEQ_DONE);
  assign halted = halted_q;
  assign entry  = entry_q;
  assign step   = step_q;

  assert_done_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> idle);
  assert_done_after_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(run));
endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int WORD_W    = 16,
  parameter int TYPE_W    = 8,
  parameter int SEG_SHIFT = 4,
  parameter int STEP_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              run,
  input  logic              entry,
  input  logic [STEP_W-1:0] step,
  input  logic [TYPE_W-1:0] take_type,
  input  logic [WORD_W-1:0] flags_in,
  input  logic [WORD_W-1:0] cs_in,
  input  logic [WORD_W-1:0] ip_in,
  input  logic [WORD_W-1:0] ss_in,
  input  logic [WORD_W-1:0] sp_in,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [7:0]        mem_wdata,
  output logic [WORD_W-1:0] new_flags,
  output logic [WORD_W-1:0] new_cs,
  output logic [WORD_W-1:0] new_ip,
  output logic [WORD_W-1:0] new_sp
);
  localparam logic [WORD_W-1:0] CLR_MASK =
    (WORD_W'(1) << IE_BIT) | (WORD_W'(1) << TRAP_BIT);
  localparam logic [WORD_W-1:0] FRAME = WORD_W'(2 * SAVED_WORDS);

  logic [WORD_W-1:0] fl_q, cs_q, ip_q, ss_q, sp_q;
  logic [TYPE_W-1:0] type_q;
  logic [WORD_W-1:0] rip_q, rcs_q, rfl_q;
  logic [WORD_W-1:0] rip_d, rcs_d, rfl_d;

  logic              pushing;
  logic [1:0]        word_sel;
  logic [WORD_W-1:0] push_word, stk_off;
  logic [2:0]        ridx;
  logic [ADDR_W-1:0] seg_base, vec_addr;

  // snapshot of the architectural state, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q   <= '0;
      cs_q   <= '0;
      ip_q   <= '0;
      ss_q   <= '0;
      sp_q   <= '0;
      type_q <= '0;
    end else if (take) begin
      fl_q   <= flags_in;
      cs_q   <= cs_in;
      ip_q   <= ip_in;
      ss_q   <= ss_in;
      sp_q   <= sp_in;
      type_q <= take_type;
    end
  end

  assign pushing  = run && entry && (step < STEP_W'(PUSH_STEPS));
  assign word_sel = step[2:1];
  assign ridx     = entry ? 3'(step - STEP_W'(PUSH_STEPS)) : step[2:0];

  always_comb begin
    unique case (word_sel)
      2'd0:    push_word = fl_q;
      2'd1:    push_word = cs_q;
      default: push_word = ip_q;
    endcase
  end

  always_comb begin
    if (entry)
      stk_off = sp_q - WORD_W'({word_sel, 1'b0}) - WORD_W'(2) + WORD_W'(step[0]);
    else
      stk_off = sp_q + WORD_W'(step);
  end

  assign seg_base = ADDR_W'({ss_q, {SEG_SHIFT{1'b0}}}) + ADDR_W'(stk_off);
  assign vec_addr = ADDR_W'({type_q, 2'b00}) + ADDR_W'(ridx[1:0]);

  assign mem_we    = pushing;
  assign mem_re    = run && !pushing;
  assign mem_addr  = (entry && !pushing) ? vec_addr : seg_base;
  assign mem_wdata = step[0] ? push_word[15:8] : push_word[7:0];

  // byte capture into the word selected by the read index
  always_comb begin
    rip_d = rip_q;
    rcs_d = rcs_q;
    rfl_d = rfl_q;
    unique case (ridx[2:1])
      2'd0: if (ridx[0]) rip_d[15:8] = mem_rdata; else rip_d[7:0] = mem_rdata;
      2'd1: if (ridx[0]) rcs_d[15:8] = mem_rdata; else rcs_d[7:0] = mem_rdata;
      default: if (ridx[0]) rfl_d[15:8] = mem_rdata; else rfl_d[7:0] = mem_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rip_q <= '0;
      rcs_q <= '0;
      rfl_q <= '0;
    end else if (mem_re) begin
      rip_q <= rip_d;
      rcs_q <= rcs_d;
      rfl_q <= rfl_d;
    end
  end

  assign new_ip    = rip_q;
  assign new_cs    = rcs_q;
  assign new_flags = entry ? (fl_q & ~CLR_MASK) : rfl_q;
  assign new_sp    = entry ? (sp_q - FRAME) : (sp_q + FRAME);

  assert_single_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int WORD_W    = 16,
  parameter int TYPE_W    = 8,
  parameter int SEG_SHIFT = 4,
  parameter int STEP_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_req,
  input  logic [TYPE_W-1:0] sw_type,
  input  logic              hw_req,
  input  logic [TYPE_W-1:0] hw_type,
  input  logic              nmi_req,
  input  logic              iret_req,
  input  logic              halt_req,
  input  logic [WORD_W-1:0] flags_in,
  input  logic [WORD_W-1:0] cs_in,
  input  logic [WORD_W-1:0] ip_in,
  input  logic [WORD_W-1:0] ss_in,
  input  logic [WORD_W-1:0] sp_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [WORD_W-1:0] new_flags,
  output logic [WORD_W-1:0] new_cs,
  output logic [WORD_W-1:0] new_ip,
  output logic [WORD_W-1:0] new_sp,
  output logic              done,
  output logic              busy,
  output logic              halted
);
  logic              idle, run, entry;
  logic              take, take_entry, wake, go_halt;
  logic [TYPE_W-1:0] take_type;
  logic [STEP_W-1:0] step;

  irq_seq_arb #(.TYPE_W(TYPE_W)) u_arb (
    .idle(idle), .halted(halted), .nmi_req(nmi_req), .hw_req(hw_req),
    .ie_set(flags_in[IE_BIT]), .sw_req(sw_req), .iret_req(iret_req),
    .halt_req(halt_req), .hw_type(hw_type), .sw_type(sw_type),
    .take(take), .take_entry(take_entry), .wake(wake), .go_halt(go_halt),
    .take_type(take_type)
  );

  irq_seq_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .take(take), .take_entry(take_entry),
    .wake(wake), .go_halt(go_halt), .idle(idle), .run(run), .done(done),
    .halted(halted), .entry(entry), .step(step)
  );

  irq_seq_dp #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .TYPE_W(TYPE_W),
    .SEG_SHIFT(SEG_SHIFT), .STEP_W(STEP_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .take(take), .run(run), .entry(entry),
    .step(step), .take_type(take_type), .flags_in(flags_in), .cs_in(cs_in),
    .ip_in(ip_in), .ss_in(ss_in), .sp_in(sp_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .new_flags(new_flags), .new_cs(new_cs),
    .new_ip(new_ip), .new_sp(new_sp)
  );

  assign busy = !idle;

  assert_masked_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && hw_req && !flags_in[IE_BIT] && !nmi_req && !sw_req && !iret_req) |=> !busy);
  assert_nmi_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && nmi_req) |=> (busy && !halted));
  assert_halt_blocks_sw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && halted && !nmi_req && !(hw_req && flags_in[IE_BIT])) |=> (!busy && halted));
endmodule

// File: tb/irq_seq_top_bench.sv
module irq_seq_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_req, hw_req, nmi_req, iret_req, halt_req;
  logic [7:0]  sw_type, hw_type;
  logic [15:0] flags_in, cs_in, ip_in, ss_in, sp_in;
  logic [19:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] new_flags, new_cs, new_ip, new_sp;
  logic        done, busy, halted;

  always #5 clk = ~clk;

  irq_seq_top u_irq_seq_top (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_type(sw_type),
    .hw_req(hw_req), .hw_type(hw_type), .nmi_req(nmi_req),
    .iret_req(iret_req), .halt_req(halt_req), .flags_in(flags_in),
    .cs_in(cs_in), .ip_in(ip_in), .ss_in(ss_in), .sp_in(sp_in),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .new_flags(new_flags),
    .new_cs(new_cs), .new_ip(new_ip), .new_sp(new_sp), .done(done),
    .busy(busy), .halted(halted)
  );

  // byte memory
  logic [7:0] bmem [int];
  function automatic logic [7:0] mrd(input int a);
    return bmem.exists(a) ? bmem[a] : 8'h00;
  endfunction
  always @(*) mem_rdata = mrd(int'(mem_addr));
  always @(posedge clk) if (mem_we) bmem[int'(mem_addr)] = mem_wdata;

  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R10";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  typedef struct { bit we; int addr; int data; } acc_t;
  acc_t q[$];
  int m_st;   // 0 idle, 1 running, 2 done
  bit m_halt, m_entry;
  int e_ip, e_cs, e_fl, e_sp;

  function automatic int phys(input int ss, input int off);
    return ((ss << 4) + (off & 16'hFFFF)) & 20'hFFFFF;
  endfunction

  task automatic build_entry(input int t);
    int words[3];
    int s;
    acc_t a;
    words[0] = flags_in; words[1] = cs_in; words[2] = ip_in;
    s = sp_in;
    q.delete();
    for (int w = 0; w < 3; w++) begin
      s = (s - 2) & 16'hFFFF;
      a.we = 1; a.addr = phys(ss_in, s);     a.data = words[w] & 8'hFF;   q.push_back(a);
      a.we = 1; a.addr = phys(ss_in, s + 1); a.data = (words[w] >> 8) & 8'hFF; q.push_back(a);
    end
    for (int i = 0; i < 4; i++) begin
      a.we = 0; a.addr = t * 4 + i; a.data = 0; q.push_back(a);
    end
    e_ip = {mrd(t*4+1), mrd(t*4)};
    e_cs = {mrd(t*4+3), mrd(t*4+2)};
    e_fl = flags_in & 16'hFCFF;
    e_sp = (sp_in - 6) & 16'hFFFF;
    m_entry = 1;
  endtask

  task automatic build_return();
    acc_t a;
    int b[6];
    q.delete();
    for (int i = 0; i < 6; i++) begin
      a.we = 0; a.addr = phys(ss_in, sp_in + i); a.data = 0; q.push_back(a);
      b[i] = mrd(a.addr);
    end
    e_ip = b[0] | (b[1] << 8);
    e_cs = b[2] | (b[3] << 8);
    e_fl = b[4] | (b[5] << 8);
    e_sp = (sp_in + 6) & 16'hFFFF;
    m_entry = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_halt = 0; q.delete();
    end else begin
      case (m_st)
        0: begin
          if (nmi_req) begin build_entry(2); m_st = 1; m_halt = 0; end
          else if (hw_req && flags_in[9]) begin build_entry(hw_type); m_st = 1; m_halt = 0; end
          else if (!m_halt && sw_req) begin build_entry(sw_type); m_st = 1; end
          else if (!m_halt && iret_req) begin build_return(); m_st = 1; end
          else if (halt_req) m_halt = 1;
        end
        1: begin
          void'(q.pop_front());
          if (q.size() == 0) m_st = 2;
        end
        default: m_st = 0;
      endcase
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk(busy == (m_st != 0), cur_tag, busy, m_st != 0);
    chk(done == (m_st == 2), "R9", done, m_st == 2);
    chk(halted == m_halt, cur_tag, halted, m_halt);
    if (m_st == 1 && q.size() > 0) begin
      chk(mem_we == q[0].we && mem_re == !q[0].we, m_entry ? "R2" : "R4", mem_we, q[0].we);
      chk(int'(mem_addr) == q[0].addr, m_entry ? "R1" : "R4", mem_addr, q[0].addr);
      if (q[0].we) chk(int'(mem_wdata) == q[0].data, "R2", mem_wdata, q[0].data);
    end
    if (m_st == 2) begin
      chk(int'(new_ip) == e_ip, m_entry ? "R1" : "R4", new_ip, e_ip);
      chk(int'(new_cs) == e_cs, m_entry ? "R1" : "R4", new_cs, e_cs);
      chk(int'(new_flags) == e_fl, m_entry ? "R3" : "R4", new_flags, e_fl);
      chk(int'(new_sp) == e_sp, m_entry ? "R3" : "R4", new_sp, e_sp);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wait_idle();
    while (m_st != 0) tick(1);
  endtask
  task automatic set_ctx(input int fl, input int cs, input int ip, input int ss, input int sp);
    flags_in = fl; cs_in = cs; ip_in = ip; ss_in = ss; sp_in = sp;
  endtask
  task automatic sw_pulse(input int t);
    sw_req = 1; sw_type = t; tick(1); sw_req = 0;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sw_req = 0; hw_req = 0; nmi_req = 0; iret_req = 0; halt_req = 0;
    sw_type = 0; hw_type = 0;
    set_ctx(16'h0302, 16'h1234, 16'h5678, 16'h2000, 16'h0100);
    for (int t = 0; t < 256; t++)
      for (int i = 0; i < 4; i++)
        bmem[t*4+i] = 8'((t * 7 + i * 13 + 1) & 8'hFF);
    tick(3);
    // R10: reset values
    chk(busy == 0 && done == 0 && halted == 0, "R10", {busy, done, halted}, 0);
    rst_n = 1;
    tick(2);

    // R1 R2 R3 R9: software entry with type 23h
    cur_tag = "R9";
    sw_pulse(8'h23); wait_idle(); tick(1);

    // R4: return from the frame just written
    set_ctx(16'h0000, 16'hAAAA, 16'hBBBB, 16'h2000, 16'h00FA);
    iret_req = 1; tick(1); iret_req = 0; wait_idle(); tick(1);

    // R5: masked request ignored, then taken once enabled
    cur_tag = "R5";
    set_ctx(16'h00C5, 16'h4000, 16'h0010, 16'h3000, 16'h0800);
    hw_req = 1; hw_type = 8'h40; tick(5);
    flags_in = 16'h02C5;
    while (m_st == 0) tick(1);
    hw_req = 0; wait_idle(); tick(1);

    // R6: NMI and maskable together, NMI wins with IF clear and set
    cur_tag = "R6";
    flags_in = 16'h0200; nmi_req = 1; hw_req = 1; hw_type = 8'h55;
    while (m_st == 0) tick(1);
    nmi_req = 0; hw_req = 0; wait_idle(); tick(1);
    flags_in = 16'h0000; nmi_req = 1;
    while (m_st == 0) tick(1);
    nmi_req = 0; wait_idle(); tick(1);

    // R7: hardware request arriving during software entry waits for it
    cur_tag = "R7";
    flags_in = 16'h0200;
    sw_pulse(8'h10); tick(2);
    hw_req = 1; hw_type = 8'h41;
    while (m_st != 2) tick(1);
    while (m_st != 1) tick(1);
    hw_req = 0; wait_idle(); tick(1);
    // R7: software and return together, software wins
    sw_req = 1; sw_type = 8'h11; iret_req = 1; tick(1); sw_req = 0; iret_req = 0;
    wait_idle(); tick(1);

    // R8: halt, ignored strobes, masked request, NMI wakes
    cur_tag = "R8";
    flags_in = 16'h0000;
    halt_req = 1; tick(1); halt_req = 0; tick(1);
    sw_pulse(8'h30); tick(2);
    iret_req = 1; tick(1); iret_req = 0; tick(2);
    hw_req = 1; hw_type = 8'h60; tick(4);
    nmi_req = 1;
    while (m_st == 0) tick(1);
    nmi_req = 0; hw_req = 0; wait_idle(); tick(1);
    // R8: halt then enabled maskable wakes
    halt_req = 1; tick(1); halt_req = 0; tick(2);
    flags_in = 16'h0200; hw_req = 1; hw_type = 8'h61;
    while (m_st == 0) tick(1);
    hw_req = 0; wait_idle(); tick(1);

    // R2 R1: offset and physical wrap, last vector entry
    cur_tag = "R2";
    set_ctx(16'hFFFF, 16'h0F0F, 16'hF0F0, 16'hFFFF, 16'h0002);
    sw_pulse(8'hFF); wait_idle(); tick(1);
    set_ctx(16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFC);
    iret_req = 1; tick(1); iret_req = 0; wait_idle(); tick(2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule